// File: doc/BRIEF.md
# Crate Trigger Sum and Uplink Packer

This block combines the trigger streams of up to sixteen digitizer boards in one crate into one 64-bit uplink word per 125 MHz cycle. Each input lane delivers a 32-bit word that holds two consecutive 250 MHz samples, the earlier one in the low half. The block keeps the two sample slots apart all the way through, so the uplink word still describes both 4 ns time slices.

A mode select chooses how the lanes are combined. In energy mode the block adds the 16-bit energy values of all enabled lanes. In hit-count mode it ORs the 16-bit hit vectors and reports how many bits are set. In tagger mode it reports the lowest and highest set index of the OR'ed vector. A per-lane enable mask removes boards from the combination. Every output word carries the 8-bit timestamp that was sampled together with its inputs, and a 16-bit check field. The latency is fixed, so the downstream system can line words up by arrival time.

Top module: `crate_trig_packer`

## Requirements
- R1: Lane k occupies bits 32k+31 down to 32k of `inData`. Within a lane, bits 15:0 are the earlier sample (slot t0) and bits 31:16 are the later sample (slot t1).
- R2: With `modeSel`=0 (energy), `outWord[19:0]` is the sum of the t0 fields of all enabled lanes and `outWord[39:20]` is the sum of their t1 fields. The sums are exact, with no overflow, up to sixteen lanes at 0xFFFF.
- R3: With `modeSel`=1 (hit count), `outWord[8:0]` is the number of set bits in the OR of the t0 hit vectors of the enabled lanes, and `outWord[17:9]` is the same count for t1. `outWord[39:18]` is zero.
- R4: With `modeSel`=2 (tagger), `outWord[7:0]` and `outWord[15:8]` are the lowest and highest set bit index of the OR'ed t0 vector. `outWord[23:16]` and `outWord[31:24]` are the same indices for t1. `outWord[39:32]` is zero.
- R5: In tagger mode, a slot whose OR'ed vector has no bit set reports 0xFF for both its minimum and its maximum.
- R6: With `modeSel`=3, `outWord[39:0]` is zero.
- R7: A lane whose `enableMask` bit is 0 has no effect on the output, whatever its data.
- R8: `outWord[47:40]` equals the value `tstamp` had in the cycle the input word was accepted.
- R9: `outWord[63:48]` is the XOR of `outWord[47:32]`, `outWord[31:16]` and `outWord[15:0]`.
- R10: An input word accepted with `inValid` high at one rising edge appears at the output, with `outValid` high, two rising edges later. Back-to-back input words give one output word per cycle.
- R11: Reset clears `outValid` and `outWord`. While `outValid` is low, `outWord` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | All lanes carry a new word this cycle |
| inData | input | NUM_IN*32 | Lane words, lane k at bits 32k+31:32k |
| enableMask | input | NUM_IN | Per-lane enable |
| modeSel | input | 2 | 0 energy, 1 hit count, 2 tagger, 3 payload zero |
| tstamp | input | 8 | Timestamp sampled together with the lanes |
| outValid | output | 1 | New packed word present |
| outWord | output | 64 | Packed uplink word |

## Verification
The assertions assume that `inValid` is low while reset is held, so the delayed-valid property never looks at an input from before reset. They also assume that mode, mask and timestamp are only meaningful in cycles where `inValid` is high. The bench drives every input on the falling edge and holds `inValid` low through reset. It changes mode and mask only together with a new valid word, and it samples outputs on the falling edge two edges after each word.

// File: rtl/crate_trig_pkg.sv
package crate_trig_pkg;
  localparam int SLOT_W   = 16;
  localparam int LANE_W   = 2 * SLOT_W;
  localparam int ENERGY_W = 20;
  localparam int COUNT_W  = 9;
  localparam int IDX_W    = 8;
  localparam int TS_W     = 8;
  localparam int WORD_W   = 64;

  typedef enum logic [1:0] {
    MODE_ENERGY = 2'd0,
    MODE_COUNT  = 2'd1,
    MODE_TAGGER = 2'd2,
    MODE_NONE   = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic capture;
    logic pack;
  } pipe_strobe_t;

  function automatic logic [COUNT_W-1:0] bitCount(input logic [SLOT_W-1:0] v);
    logic [COUNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < SLOT_W; i++) n = n + COUNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic [IDX_W-1:0] lowIndex(input logic [SLOT_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '1;
    for (int i = SLOT_W - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] highIndex(input logic [SLOT_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '1;
    for (int i = 0; i < SLOT_W; i++) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/crate_trig_ctrl.sv
module crate_trig_ctrl
  import crate_trig_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output pipe_strobe_t strobes,
  output logic         outValid
);
  logic stageOneV;
  logic stageTwoV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stageOneV <= 1'b0;
      stageTwoV <= 1'b0;
    end else begin
      stageOneV <= inValid;
      stageTwoV <= stageOneV;
    end
  end

  always_comb begin
    strobes.capture = inValid;
    strobes.pack    = stageOneV;
  end

  assign outValid = stageTwoV;

  // R10
  pack_follows_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.pack |-> $past(strobes.capture));
endmodule

// File: rtl/crate_trig_datapath.sv
module crate_trig_datapath
  import crate_trig_pkg::*;
#(
  parameter int NUM_IN = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  pipe_strobe_t             strobes,
  input  logic [NUM_IN*LANE_W-1:0] inData,
  input  logic [NUM_IN-1:0]        enableMask,
  input  logic [1:0]               modeSel,
  input  logic [TS_W-1:0]          tstamp,
  output logic [WORD_W-1:0]        outWord
);
  localparam int PAYLOAD_W = 40;

  logic [LANE_W-1:0] laneQ [NUM_IN];
  trig_mode_e        modeQ;
  logic [TS_W-1:0]   tsQ;

  // stage 1: masked lane capture
  for (genvar k = 0; k < NUM_IN; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                laneQ[k] <= '0;
      else if (strobes.capture)  laneQ[k] <= enableMask[k] ? inData[k*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ <= MODE_ENERGY;
      tsQ   <= '0;
    end else if (strobes.capture) begin
      modeQ <= trig_mode_e'(modeSel);
      tsQ   <= tstamp;
    end
  end

  // stage 2: reduce per slot
  logic [ENERGY_W-1:0] sumT0, sumT1;
  logic [SLOT_W-1:0]   hitT0, hitT1;

  always_comb begin
    sumT0 = '0;
    sumT1 = '0;
    hitT0 = '0;
    hitT1 = '0;
    for (int k = 0; k < NUM_IN; k++) begin
      sumT0 = sumT0 + ENERGY_W'(laneQ[k][SLOT_W-1:0]);
      sumT1 = sumT1 + ENERGY_W'(laneQ[k][LANE_W-1:SLOT_W]);
      hitT0 = hitT0 | laneQ[k][SLOT_W-1:0];
      hitT1 = hitT1 | laneQ[k][LANE_W-1:SLOT_W];
    end
  end

  logic [IDX_W-1:0] minT0, maxT0, minT1, maxT1;
  assign minT0 = lowIndex(hitT0);
  assign maxT0 = highIndex(hitT0);
  assign minT1 = lowIndex(hitT1);
  assign maxT1 = highIndex(hitT1);

  logic [PAYLOAD_W-1:0] payload;
  always_comb begin
    unique case (modeQ)
      MODE_ENERGY: payload = {sumT1, sumT0};
      MODE_COUNT:  payload = {22'd0, bitCount(hitT1), bitCount(hitT0)};
      MODE_TAGGER: payload = {8'd0, maxT1, minT1, maxT0, minT0};
      default:     payload = '0;
    endcase
  end

  logic [47:0] body;
  logic [15:0] checkField;
  assign body       = {tsQ, payload};
  assign checkField = body[47:32] ^ body[31:16] ^ body[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n)            outWord <= '0;
    else if (strobes.pack) outWord <= {checkField, body};
  end

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.pack |=> $stable(outWord));

  // R3
  count_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.pack && modeQ == MODE_COUNT) |=> outWord[39:18] == '0);

  // R5
  tagger_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.pack && modeQ == MODE_TAGGER) |=>
      ((outWord[7:0] <= outWord[15:8]) && (outWord[23:16] <= outWord[31:24])
       && outWord[39:32] == '0));

  // R6
  none_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.pack && modeQ == MODE_NONE) |=> outWord[39:0] == '0);
endmodule

// File: rtl/crate_trig_packer.sv
module crate_trig_packer
  import crate_trig_pkg::*;
#(
  parameter int NUM_IN = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  input  logic [NUM_IN*LANE_W-1:0] inData,
  input  logic [NUM_IN-1:0]        enableMask,
  input  logic [1:0]               modeSel,
  input  logic [TS_W-1:0]          tstamp,
  output logic                     outValid,
  output logic [WORD_W-1:0]        outWord
);
  pipe_strobe_t strobes;

  crate_trig_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  crate_trig_datapath #(.NUM_IN(NUM_IN)) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .inData     (inData),
    .enableMask (enableMask),
    .modeSel    (modeSel),
    .tstamp     (tstamp),
    .outWord    (outWord)
  );

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> $past(inValid, 2));

  // R9
  check_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outWord[63:48] == (outWord[47:32] ^ outWord[31:16] ^ outWord[15:0]));

  // R8
  stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outWord[47:40] == $past(tstamp, 2));
endmodule

// File: tb/test_crate_trig_packer.sv
module test_crate_trig_packer;
  localparam int CLK_PERIOD = 8;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic [N*32-1:0] inData = '0;
  logic [N-1:0]  enableMask = '0;
  logic [1:0]    modeSel = '0;
  logic [7:0]    tstamp = '0;
  logic          outValid;
  logic [63:0]   outWord;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crate_trig_packer #(.NUM_IN(N)) i_crate_trig_packer (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData),
    .enableMask(enableMask), .modeSel(modeSel), .tstamp(tstamp),
    .outValid(outValid), .outWord(outWord)
  );

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic logic [63:0] model(input logic [N*32-1:0] d, input logic [N-1:0] m,
                                        input logic [1:0] md, input logic [7:0] ts);
    logic [19:0] s0, s1;
    logic [15:0] h0, h1;
    logic [39:0] pl;
    logic [47:0] b;
    int c0, c1, lo0, hi0, lo1, hi1;
    s0 = 0; s1 = 0; h0 = 0; h1 = 0;
    for (int k = 0; k < N; k++) if (m[k]) begin
      s0 += {4'd0, d[k*32 +: 16]};
      s1 += {4'd0, d[k*32+16 +: 16]};
      h0 |= d[k*32 +: 16];
      h1 |= d[k*32+16 +: 16];
    end
    c0 = 0; c1 = 0; lo0 = 255; hi0 = 255; lo1 = 255; hi1 = 255;
    for (int i = 0; i < 16; i++) begin
      if (h0[i]) begin c0++; if (lo0 == 255) lo0 = i; hi0 = i; end
      if (h1[i]) begin c1++; if (lo1 == 255) lo1 = i; hi1 = i; end
    end
    case (md)
      2'd0: pl = {s1, s0};
      2'd1: pl = {22'd0, 9'(c1), 9'(c0)};
      2'd2: pl = {8'd0, 8'(hi1), 8'(lo1), 8'(hi0), 8'(lo0)};
      default: pl = '0;
    endcase
    b = {ts, pl};
    return {b[47:32] ^ b[31:16] ^ b[15:0], b};
  endfunction

  // one isolated word: drive, wait two edges, check
  task automatic single(input string req, input logic [N*32-1:0] d, input logic [N-1:0] m,
                        input logic [1:0] md, input logic [7:0] ts);
    @(negedge clk);
    inData = d; enableMask = m; modeSel = md; tstamp = ts; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inData = '1; tstamp = 8'h5A;
    @(negedge clk);
    check({req, " valid"}, 64'(outValid), 64'd1);
    check(req, outWord, model(d, m, md, ts));
  endtask

  function automatic logic [N*32-1:0] pattern(input int seed);
    logic [N*32-1:0] d;
    for (int k = 0; k < N; k++) d[k*32 +: 32] = 32'(k * 32'h9E37_79B1 + seed * 32'h0101_0305);
    return d;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R11 reset valid", 64'(outValid), 64'd0);
    check("R11 reset word", outWord, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_energy();
    single("R2 R1 energy mix", pattern(1), 16'hFFFF, 2'd0, 8'h11);
    single("R2 energy max no overflow", '1, 16'hFFFF, 2'd0, 8'h12);
    begin
      logic [N*32-1:0] d = '0;
      d[15:0] = 16'h0003; d[31:16] = 16'h0100;
      single("R1 slot order", d, 16'h0001, 2'd0, 8'h13);
      check("R1 t0 field", 64'(outWord[19:0]), 64'h3);
      check("R1 t1 field", 64'(outWord[39:20]), 64'h100);
    end
  endtask

  task automatic t_mask();
    single("R7 mask subset", pattern(2), 16'hA5C3, 2'd0, 8'h21);
    single("R7 all disabled", pattern(3), 16'h0000, 2'd0, 8'h22);
    check("R7 zero payload", 64'(outWord[39:0]), 64'd0);
  endtask

  task automatic t_count();
    logic [N*32-1:0] d = '0;
    d[0 +: 32]  = 32'h0003_8001;
    d[32 +: 32] = 32'h0001_8002;
    d[64 +: 32] = 32'hFFFF_FFFF;
    single("R3 count overlap", d, 16'h0003, 2'd1, 8'h31);
    check("R3 t0 count", 64'(outWord[8:0]), 64'd3);
    check("R3 t1 count", 64'(outWord[17:9]), 64'd2);
    single("R3 count full", d, 16'h0007, 2'd1, 8'h32);
    check("R3 t0 count full", 64'(outWord[8:0]), 64'd16);
  endtask

  task automatic t_tagger();
    logic [N*32-1:0] d = '0;
    d[0 +: 32]   = 32'h0010_0100;
    d[160 +: 32] = 32'h0400_0004;
    single("R4 tagger", d, 16'h0021, 2'd2, 8'h41);
    check("R4 min t0", 64'(outWord[7:0]), 64'd2);
    check("R4 max t0", 64'(outWord[15:8]), 64'd8);
    check("R4 min t1", 64'(outWord[23:16]), 64'd4);
    check("R4 max t1", 64'(outWord[31:24]), 64'd10);
    d[0 +: 32] = 32'h0000_0000;
    d[160 +: 32] = 32'h8000_0000;
    single("R5 tagger empty t0", d, 16'h0021, 2'd2, 8'h42);
    check("R5 empty min", 64'(outWord[7:0]), 64'hFF);
    check("R5 empty max", 64'(outWord[15:8]), 64'hFF);
    check("R4 single bit t1", 64'(outWord[31:16]), 64'h0F0F);
  endtask

  task automatic t_none();
    single("R6 mode3", pattern(4), 16'hFFFF, 2'd3, 8'h61);
    check("R6 payload zero", 64'(outWord[39:0]), 64'd0);
    check("R8 stamp", 64'(outWord[47:40]), 64'h61);
    check("R9 check", 64'(outWord[63:48]), 64'(16'h6100));
  endtask

  task automatic t_stream();
    logic [63:0] exp [5];
    logic [63:0] held;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R10 stream valid", 64'(outValid), 64'd1);
        check("R10 R8 stream word", outWord, exp[i-2]);
      end
      inData = pattern(10 + i); enableMask = 16'hFFFF; modeSel = 2'(i % 3);
      tstamp = 8'(8'h70 + i); inValid = 1'b1;
      exp[i] = model(inData, enableMask, modeSel, tstamp);
    end
    @(negedge clk);
    inValid = 1'b0;
    check("R10 stream word", outWord, exp[3]);
    @(negedge clk);
    check("R10 stream last", outWord, exp[4]);
    held = outWord;
    @(negedge clk);
    check("R11 valid drops", 64'(outValid), 64'd0);
    inData = pattern(99);
    repeat (3) @(negedge clk);
    check("R11 hold", outWord, held);
  endtask

  initial begin
    t_reset();
    t_energy();
    t_mask();
    t_count();
    t_tagger();
    t_none();
    t_stream();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule